// File: doc/BRIEF.md
# GPIO Pad Interrupt Controller

A memory-mapped controller for a bank of general-purpose pads. Every pad has a configuration word choosing how it raises interrupts and whether it bypasses the shared interrupt, plus a value word used to drive the pad output and to read back the synchronized pad input. Pad inputs cross into the clock domain through a two-flop synchronizer. Edge or level events are then detected and latched into pending-status words. Each status word covers 32 pads.

Software reads a status word and writes the same value back to acknowledge it. The single interrupt line is high while any status bit is pending. A pad marked for direct routing never enters the status words. Its trigger condition appears instead on its own bit of a dedicated output vector.

The register bus is a single-cycle strobe. A write is taken at the rising clock edge where `req_i` and `we_i` are both high. Read data is combinational from `addr_i`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset all configuration, output-level and status bits are zero, so `irq_o`, `pad_out_o` and `direct_o` are all zero.
- R2: A write to the value word of pad n (byte address n*16+8) sets `pad_out_o[n]` to bit 0 of the write data. The change is visible after the write's clock edge.
- R3: A read of the value word of pad n returns the synchronized input in bit 0, with all other bits zero. A change on `pad_in_i[n]` appears there after the second rising edge.
- R4: The configuration word of pad n (byte address n*16) stores only bits 24 to 27. A read returns those bits and zero everywhere else.
- R5: In edge mode (bit 24 clear), bit 25 flags rising edges, bit 26 flags falling edges, and both together flag either edge. The status bit is set on the third rising edge after the input changes.
- R6: In level mode (bit 24 set), the status bit is set whenever the input is at the active level: high for bit 25, low for bit 26. It sets again the cycle after a clear while that level persists.
- R7: A pad with bits 24, 25 and 26 all clear never sets its status bit.
- R8: A pad with bit 27 set never sets its status bit. Its trigger condition drives `direct_o[n]` instead, and that bit is zero for every other pad.
- R9: Status word w sits at byte address 0x800 + 4*w. Pad n is at bit n mod 32 of word n/32. Bits for pads that do not exist read zero.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a new event lands in the same cycle as the clear, the bit stays set.
- R11: `irq_o` is high exactly when at least one status bit is set.
- R12: Reads of any address that is not a configuration, value or existing status word return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pad_in_i | input | NUM_PADS | Asynchronous pad inputs |
| pad_out_o | output | NUM_PADS | Pad output levels |
| direct_o | output | NUM_PADS | Per-pad trigger for directly routed pads |
| irq_o | output | 1 | Shared interrupt |

## Verification
The results of this block fall due at fixed delays, counted in rising edges:
- Written configuration and output levels appear one edge after the write strobe.
- A pad input change reaches the value word after two edges.
- The same change reaches the status bit and `irq_o` after three edges.
- A status clear takes effect on the edge of its write.

The latency and collision tests change a pad just after a falling edge and then count rising edges explicitly. They sample at the falling edge that follows the edge where the result is due, and one edge earlier to prove the result is not premature. The mode sweeps allow five settling cycles before each read, so their checks do not depend on exact latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int CFG_LSB = 24;
  localparam logic [3:0] OFS_CFG = 4'h0;
  localparam logic [3:0] OFS_VAL = 4'h8;

  // packed MSB first so it maps directly onto config bits 27:24
  typedef struct packed {
    logic direct;
    logic neg;
    logic pos;
    logic level;
  } pad_cfg_t;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pad_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_pad_detect.sv
module gpio_pad_detect
  import gpio_irq_pkg::*;
#(
  parameter int N = 8
) (
  input  pad_cfg_t     cfg_i [N],
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] prev_i,
  output logic [N-1:0] set_o,
  output logic [N-1:0] direct_o
);
  for (genvar n = 0; n < N; n++) begin : g_pad
    logic rise, fall, trig;
    assign rise = sync_i[n] & ~prev_i[n];
    assign fall = ~sync_i[n] & prev_i[n];
    assign trig = cfg_i[n].level
                ? ((cfg_i[n].pos & sync_i[n]) | (cfg_i[n].neg & ~sync_i[n]))
                : ((cfg_i[n].pos & rise) | (cfg_i[n].neg & fall));
    assign set_o[n]    = trig & ~cfg_i[n].direct;
    assign direct_o[n] = trig & cfg_i[n].direct;
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;

  // new event beats a simultaneous write-1 clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;

  for (genvar n = 0; n < N; n++) begin : g_ast
    AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[n] |=> status_q[n]) else $error("event lost"); // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[n] && !set_i[n]) |=> !status_q[n]) else $error("clear ignored"); // R10
    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_q[n]) |-> $past(set_i[n])) else $error("spurious status"); // R5
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS    = 40,
  parameter int ADDR_W      = 12,
  parameter int STATUS_BASE = 'h800
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PADS-1:0] pad_in_i,
  output logic [NUM_PADS-1:0] pad_out_o,
  output logic [NUM_PADS-1:0] direct_o,
  output logic                irq_o
);
  localparam int NUM_WORDS = (NUM_PADS + 31) / 32;
  localparam int PAD_IW    = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam int WORD_IW   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  pad_cfg_t            cfg_q [NUM_PADS];
  logic [NUM_PADS-1:0] out_q, sync, prev, set, clr, status;

  // address decode
  logic [ADDR_W-5:0]  pad_idx;
  logic [PAD_IW-1:0]  pad_sel;
  logic [3:0]         ofs;
  logic               pad_ok;
  logic [ADDR_W-1:0]  word_off;
  logic [ADDR_W-3:0]  word_idx;
  logic [WORD_IW-1:0] word_sel;
  logic               st_ok, wr_st;

  assign pad_idx  = addr_i[ADDR_W-1:4];
  assign pad_sel  = pad_idx[PAD_IW-1:0];
  assign ofs      = addr_i[3:0];
  assign pad_ok   = (int'(addr_i) < STATUS_BASE) && (int'(pad_idx) < NUM_PADS);
  assign word_off = addr_i - ADDR_W'(STATUS_BASE);
  assign word_idx = word_off[ADDR_W-1:2];
  assign word_sel = word_idx[WORD_IW-1:0];
  assign st_ok    = (int'(addr_i) >= STATUS_BASE) && (word_off[1:0] == 2'b00)
                    && (int'(word_idx) < NUM_WORDS);
  assign wr_st    = req_i && we_i && st_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PADS; i++) cfg_q[i] <= '0;
      out_q <= '0;
    end else if (req_i && we_i && pad_ok) begin
      if (ofs == OFS_CFG) cfg_q[pad_sel] <= pad_cfg_t'(wdata_i[CFG_LSB+3:CFG_LSB]);
      else if (ofs == OFS_VAL) out_q[pad_sel] <= wdata_i[0];
    end
  end

  for (genvar n = 0; n < NUM_PADS; n++) begin : g_clr
    assign clr[n] = wr_st && (int'(word_sel) == n / 32) && wdata_i[n % 32];
  end

  // status bits padded to whole words for read-out
  logic [NUM_WORDS*32-1:0] st_full;
  for (genvar b = 0; b < NUM_WORDS * 32; b++) begin : g_pad_st
    if (b < NUM_PADS) begin : g_real
      assign st_full[b] = status[b];
    end else begin : g_zero
      assign st_full[b] = 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (pad_ok) begin
      if (ofs == OFS_CFG)      rdata_o[CFG_LSB+3:CFG_LSB] = cfg_q[pad_sel];
      else if (ofs == OFS_VAL) rdata_o[0] = sync[pad_sel];
    end else if (st_ok) begin
      rdata_o = st_full[{word_sel, 5'b0} +: 32];
    end
  end

  gpio_pad_sync #(.N(NUM_PADS)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .pad_i(pad_in_i),
    .sync_o(sync),  .prev_o(prev)
  );

  gpio_pad_detect #(.N(NUM_PADS)) u_detect (
    .cfg_i (cfg_q), .sync_i(sync), .prev_i(prev),
    .set_o (set),   .direct_o(direct_o)
  );

  gpio_irq_status #(.N(NUM_PADS)) u_status (
    .clk_i (clk_i), .rst_ni(rst_ni), .set_i(set), .clr_i(clr), .status_o(status)
  );

  assign pad_out_o = out_q;
  assign irq_o     = |status;

  AST_IRQ_FALL_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_st)) else $error("irq dropped without ack"); // R11

  for (genvar n = 0; n < NUM_PADS; n++) begin : g_ast
    AST_DIRECT_NEVER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status[n]) |-> !$past(cfg_q[n].direct)) else $error("direct pad pending"); // R8
  end
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int NP = 40;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, direct;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PADS(NP), .ADDR_W(AW), .STATUS_BASE('h800)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .direct_o(direct), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_status(output logic [NP-1:0] s);
    logic [31:0] w0, w1;
    rd(12'h800, w0);
    rd(12'h804, w1);
    s = {w1[NP-33:0], w0};
  endtask

  task automatic clear_all();
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'h804, 32'hFFFF_FFFF);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode n%7: 0 rise, 1 fall, 2 both edges, 3 level high, 4 level low, 5 none, 6 level high direct
  function automatic logic [31:0] mode_cfg(input int m);
    case (m)
      0: return 32'h0200_0000;
      1: return 32'h0400_0000;
      2: return 32'h0600_0000;
      3: return 32'h0300_0000;
      4: return 32'h0500_0000;
      6: return 32'h0B00_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [NP-1:0] mask(input int m);
    logic [NP-1:0] r = '0;
    for (int n = 0; n < NP; n++) if (n % 7 == m) r[n] = 1'b1;
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0]   d;
    logic [NP-1:0] s, exp_out;
    logic [NP-1:0] pat;

    // R1 reset state
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 irq", irq, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 direct", direct, 0);
    rd_status(s);
    chk("R1 status", s, 0);
    rd(12'h000, d);
    chk("R1 cfg pad0", d, 0);

    // R2 output level sweep
    exp_out = '0;
    for (int n = 0; n < NP; n++) begin
      wr(AW'(n * 16 + 8), {31'b0, 1'b1});
      exp_out[n] = 1'b1;
      chk("R2 set", pad_out, exp_out);
    end
    for (int n = 0; n < NP; n += 3) begin
      wr(AW'(n * 16 + 8), 32'hFFFF_FFFE);
      exp_out[n] = 1'b0;
    end
    chk("R2 pattern", pad_out, exp_out);

    // R3 input read sweep
    pat = 40'hA5_3C_96_0F_E1;
    pad_in = pat;
    idle(4);
    for (int n = 0; n < NP; n++) begin
      rd(AW'(n * 16 + 8), d);
      chk("R3 value", d, {31'b0, pat[n]});
    end
    pad_in = '0;
    idle(4);

    // R4 config storage
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, d);
    chk("R4 cfg bits", d, 32'h0F00_0000);
    wr(12'h050, 32'h0);
    rd(12'h050, d);
    chk("R4 cfg clear", d, 0);
    clear_all();

    // R5 R3 R11 exact latency on pad 3, rising edge only
    wr(12'h030, 32'h0200_0000);
    idle(2);
    clear_all();
    addr = 12'h038;
    @(negedge clk);
    pad_in[3] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R3 value after 1 edge", rdata, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 value after 2 edges", rdata, 1);
    chk("R5 irq not before 3 edges", irq, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R5 R11 irq after 3 edges", irq, 1);
    rd(12'h800, d);
    chk("R9 pad3 bit", d, 32'h8);

    // R10 event in same cycle as clear wins
    pad_in[3] = 1'b0;
    idle(5);
    @(negedge clk);
    pad_in[3] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'h800; wdata = 32'h8;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    #1;
    chk("R10 event wins", rdata, 32'h8);
    wr(12'h800, 32'h0);
    rd(12'h800, d);
    chk("R10 write 0 keeps", d, 32'h8);
    wr(12'h800, 32'h8);
    rd(12'h800, d);
    chk("R10 write 1 clears", d, 0);
    chk("R11 irq low", irq, 0);
    pad_in = '0;

    // Mode sweep across all pads
    for (int n = 0; n < NP; n++) wr(AW'(n * 16), mode_cfg(n % 7));
    idle(5);
    clear_all();
    idle(5);
    rd_status(s);
    chk("R6 level low reasserts", s, mask(4));
    chk("R11 irq on", irq, 1);

    pad_in = '1;
    idle(6);
    rd_status(s);
    chk("R5 R6 R7 R8 rise", s, mask(0) | mask(2) | mask(3) | mask(4));
    chk("R8 direct high", direct, mask(6));
    rd(12'h004, d);
    chk("R12 cfg+4", d, 0);
    rd(12'h00C, d);
    chk("R12 cfg+12", d, 0);
    rd(AW'(NP * 16), d);
    chk("R12 missing pad", d, 0);
    rd(12'h802, d);
    chk("R12 unaligned status", d, 0);
    rd(12'h808, d);
    chk("R12 missing word", d, 0);
    rd(12'h804, d);
    chk("R9 word1 upper zero", d[31:NP-32], 0);

    clear_all();
    idle(5);
    rd_status(s);
    chk("R6 level high holds", s, mask(3));
    chk("R8 direct still high", direct, mask(6));

    pad_in = '0;
    idle(6);
    rd_status(s);
    chk("R5 R6 fall", s, mask(1) | mask(2) | mask(3) | mask(4));
    chk("R8 direct low", direct, 0);

    // R7 everything off
    for (int n = 0; n < NP; n++) wr(AW'(n * 16), 32'h0);
    clear_all();
    pad_in = '1;
    idle(6);
    pad_in = '0;
    idle(6);
    rd_status(s);
    chk("R7 no status", s, 0);
    chk("R7 R11 irq off", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule